// File: doc/BRIEF.md
# PHY Management Register Controller

This block lets software reach the management registers of an Ethernet PHY through three 16-bit host registers. Software loads the outgoing data word into a write-data register, then writes one command word that names the PHY address, the PHY register number and the kind of access (read or write). The controller turns that command into a clause-22 management frame on MDC and MDIO, and clears the request bit when the last bit has gone out. The request bit is the busy flag. Software polls the command register until the bit reads zero, and after a read it takes the result from the read-data register.

The host interface is a single-cycle register bus. Writes are sampled on the clock edge and reads are combinational from the address. The offsets are command 0x20, read data 0x24 and write data 0x28, and any other address reads as zero. MDC is the system clock divided by `MDC_DIV`. The default of 80 gives 2.5 MHz from a 200 MHz clock. MDIO is split into input, output and output-enable so that the pad can be tri-stated.

A frame state machine steps through these states: `ST_IDLE`, then `ST_PRE` for 32 ones, `ST_HDR` for the start, opcode, PHY address and register bits, `ST_TA` for turnaround, `ST_DATA` for the 16 data bits, `ST_DONE` for one clock, and back to `ST_IDLE`. The transitions are:
- IDLE to PRE on a pending request.
- PRE to HDR after the 32nd bit.
- HDR to TA after the 14th bit.
- TA to DATA after the 2nd bit.
- DATA to DONE after the 16th bit.
- DONE to IDLE always.

Each bit lasts one MDC period and changes when MDC falls.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, all three host registers read 0x0000, MDC is low and `mdio_oe` is low.
- R2: The command register at 0x20 has these fields: bits 4:0 are the PHY register number, bits 12:8 are the PHY address, bit 13 requests a read and bit 14 requests a write. All other bits read as zero and ignore writes. The write-data register at 0x28 reads back what was written. The read-data register at 0x24 ignores host writes. Unused addresses read 0.
- R3: Every frame begins with 32 ones, then the start pattern 01, then the opcode (10 for read, 01 for write), then the 5-bit PHY address and the 5-bit register number, each sent MSB first.
- R4: A write frame drives turnaround as 1 then 0, then the 16 bits of the write-data register MSB first. `mdio_oe` stays high for all 64 bits.
- R5: A read frame releases MDIO (`mdio_oe` low) for the 2 turnaround bits and the 16 data bits. It samples `mdio_i` on each MDC rising edge in the data phase, MSB first, and places the word in the read-data register when the frame completes.
- R6: The request bit reads 1 from the clock after the command write until the frame has finished. Exactly 64 MDC rising edges occur per command, and the bit then clears by hardware.
- R7: A command write that arrives while a request bit is set is ignored. The command readback is unchanged and no extra frame is produced.
- R8: MDC has a period of `MDC_DIV` clocks and is high for `MDC_DIV/2` of them. MDC is low and `mdio_oe` is low whenever no frame is in progress.
- R9: If a command write sets both bit 13 and bit 14, only the write request is kept, and the frame uses the write opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Host register byte offset |
| bus_wr | input | 1 | Host write strobe, sampled on the clock edge |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, combinational from `bus_addr` |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable |

## Verification
A small PHY model in the bench records `mdio_o` and `mdio_oe` at every MDC rise. During the read data phase it returns a word that the bench chooses. The main function is driven with random PHY addresses, register numbers, data words and operations, and the recorded frame is compared with one that the bench builds from the field layout. Random reads and writes separate opcode and ownership errors: a swapped opcode, an enable left high in turnaround, or a data word read out of order shows up as a mismatch in the recorded bits or in the read-data register. Directed cases cover the rest:
- all-ones and all-zero fields, which expose shift and bit-order errors;
- a command issued during a busy frame, which shows whether commands are locked out;
- a command with both request bits set, which shows the priority rule;
- writes to the read-only and unused offsets, which show that the register map is isolated.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA,
        ST_DONE
    } mdio_state_e;

    localparam int OFS_CMD   = 'h20;
    localparam int OFS_RDATA = 'h24;
    localparam int OFS_WDATA = 'h28;

    localparam int BIT_RD    = 13;
    localparam int BIT_WR    = 14;
    localparam int FLD_W     = 5;
    localparam int PHY_LSB   = 8;

    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 14;
    localparam int TA_BITS   = 2;
    localparam int DAT_BITS  = 16;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int MDC_DIV = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF = MDC_DIV / 2;
    localparam int CW   = (MDC_DIV > 2) ? $clog2(MDC_DIV) : 1;

    logic [CW-1:0] cnt;

    assign rise_tick = en && (cnt == CW'(HALF - 1));
    assign fall_tick = en && (cnt == CW'(MDC_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (fall_tick) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
            if (rise_tick) mdc <= 1'b1;
        end
    end

    p_mdc_low_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc);
    p_mdc_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !rise_tick && !fall_tick) |=> $stable(mdc));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_write,
    input  logic [FLD_W-1:0]  phy_addr,
    input  logic [FLD_W-1:0]  reg_num,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              clk_en,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_word
);
    localparam int SR_W = 2 + 2 + 2 * FLD_W + TA_BITS + DATA_W;

    mdio_state_e     state, state_nx;
    logic [5:0]      bit_cnt;
    logic            last_bit;
    logic            op_wr_q;
    logic [SR_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;

    always_comb begin
        unique case (state)
            ST_PRE:  last_bit = (bit_cnt == 6'(PRE_BITS - 1));
            ST_HDR:  last_bit = (bit_cnt == 6'(HDR_BITS - 1));
            ST_TA:   last_bit = (bit_cnt == 6'(TA_BITS - 1));
            ST_DATA: last_bit = (bit_cnt == 6'(DAT_BITS - 1));
            default: last_bit = 1'b0;
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)                 state_nx = ST_PRE;
            ST_PRE:  if (fall_tick && last_bit) state_nx = ST_HDR;
            ST_HDR:  if (fall_tick && last_bit) state_nx = ST_TA;
            ST_TA:   if (fall_tick && last_bit) state_nx = ST_DATA;
            ST_DATA: if (fall_tick && last_bit) state_nx = ST_DONE;
            ST_DONE:                            state_nx = ST_IDLE;
            default:                            state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            op_wr_q <= 1'b0;
            tx_sr   <= '0;
            rx_sr   <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                bit_cnt <= '0;
                op_wr_q <= op_write;
                tx_sr   <= {2'b01, (op_write ? 2'b01 : 2'b10), phy_addr, reg_num,
                            2'b10, wr_word};
            end else if (fall_tick) begin
                bit_cnt <= last_bit ? 6'd0 : bit_cnt + 6'd1;
                if (state != ST_PRE) tx_sr <= {tx_sr[SR_W-2:0], 1'b0};
            end
            if (rise_tick && state == ST_DATA)
                rx_sr <= {rx_sr[DATA_W-2:0], mdio_i};
        end
    end

    always_comb begin
        clk_en  = 1'b0;
        mdio_o  = 1'b1;
        mdio_oe = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PRE: begin
                clk_en  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_HDR: begin
                clk_en  = 1'b1;
                mdio_o  = tx_sr[SR_W-1];
                mdio_oe = 1'b1;
            end
            ST_TA, ST_DATA: begin
                clk_en  = 1'b1;
                mdio_o  = tx_sr[SR_W-1];
                mdio_oe = op_wr_q;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign rd_word = rx_sr;

    p_start_leaves_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> state == ST_PRE);
    p_shift_only_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR && !fall_tick) |=> $stable(tx_sr));
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_word,
    output logic              busy,
    output logic              op_write,
    output logic [FLD_W-1:0]  phy_addr,
    output logic [FLD_W-1:0]  reg_num,
    output logic [DATA_W-1:0] wr_word
);
    logic              rq_rd, rq_wr;
    logic [DATA_W-1:0] rdata_q;

    assign busy     = rq_rd | rq_wr;
    assign op_write = rq_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_rd    <= 1'b0;
            rq_wr    <= 1'b0;
            phy_addr <= '0;
            reg_num  <= '0;
            wr_word  <= '0;
            rdata_q  <= '0;
        end else begin
            if (done) begin
                if (rq_rd) rdata_q <= rd_word;
                rq_rd <= 1'b0;
                rq_wr <= 1'b0;
            end else if (bus_wr && bus_addr == ADDR_W'(OFS_CMD) && !busy) begin
                phy_addr <= bus_wdata[PHY_LSB +: FLD_W];
                reg_num  <= bus_wdata[FLD_W-1:0];
                rq_wr    <= bus_wdata[BIT_WR];
                rq_rd    <= bus_wdata[BIT_RD] & ~bus_wdata[BIT_WR];
            end
            if (bus_wr && bus_addr == ADDR_W'(OFS_WDATA))
                wr_word <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CMD)) begin
            bus_rdata[BIT_WR]              = rq_wr;
            bus_rdata[BIT_RD]              = rq_rd;
            bus_rdata[PHY_LSB +: FLD_W]    = phy_addr;
            bus_rdata[FLD_W-1:0]           = reg_num;
        end else if (bus_addr == ADDR_W'(OFS_RDATA)) begin
            bus_rdata = rdata_q;
        end else if (bus_addr == ADDR_W'(OFS_WDATA)) begin
            bus_rdata = wr_word;
        end
    end

    p_single_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rq_rd && rq_wr));
    p_cmd_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable({phy_addr, reg_num, rq_wr}));
    p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int MDC_DIV = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic              busy, op_write, done, clk_en, rise_tick, fall_tick;
    logic [FLD_W-1:0]  phy_addr, reg_num;
    logic [DATA_W-1:0] wr_word, rd_word;

    mdio_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .done(done), .rd_word(rd_word),
        .busy(busy), .op_write(op_write),
        .phy_addr(phy_addr), .reg_num(reg_num), .wr_word(wr_word)
    );

    mdio_clkgen #(.MDC_DIV(MDC_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .en(clk_en),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start(busy), .op_write(op_write),
        .phy_addr(phy_addr), .reg_num(reg_num), .wr_word(wr_word),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
        .clk_en(clk_en), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .done(done), .rd_word(rd_word)
    );

    p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));

endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_ctrl;
    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    mdio_mgmt_ctrl #(.ADDR_W(8), .DATA_W(16), .MDC_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always #2.5 clk = ~clk;

    // PHY model
    int          rise_cnt = 0;
    logic [63:0] rec_o, rec_oe;
    logic [15:0] phy_word = '0;
    realtime     t_rise = 0, t_prev_rise = 0, hi_time = 0, period = 0;

    always @(posedge mdc) begin
        if (rise_cnt < 64) begin
            rec_o[63-rise_cnt]  = mdio_o;
            rec_oe[63-rise_cnt] = mdio_oe;
        end
        t_prev_rise = t_rise;
        t_rise = $realtime;
        if (rise_cnt == 1) period = t_rise - t_prev_rise;
        rise_cnt = rise_cnt + 1;
    end
    always @(negedge mdc) begin
        if (rise_cnt == 1) hi_time = $realtime - t_rise;
        if (rise_cnt == 47)                        mdio_i = 1'b0;
        else if (rise_cnt >= 48 && rise_cnt < 64)  mdio_i = phy_word[63-rise_cnt];
        else                                       mdio_i = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] p,
                                              input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r, 2'b10, d};
    endfunction

    task automatic wait_free(output bit ok);
        logic [15:0] v;
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            bus_read(8'h20, v);
            if (v[14:13] == 2'b00) begin ok = 1'b1; break; end
        end
    endtask

    task automatic txn(input bit wr, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] d, input bit both);
        logic [15:0] v;
        logic [63:0] ef, eoe;
        bit ok;
        rise_cnt = 0;
        phy_word = d;
        if (wr) bus_write(8'h28, d);
        bus_write(8'h20, {1'b0, wr, (!wr) | both, p, 3'b000, r});
        bus_read(8'h20, v);
        chk(v == {1'b0, wr, !wr, p, 3'b000, r}, "R6/R9 cmd readback busy",
            64'(v), 64'({1'b0, wr, !wr, p, 3'b000, r}));
        wait_free(ok);
        chk(ok, "R6 request bit clears", 64'(ok), 64'd1);
        chk(rise_cnt == 64, "R6 MDC edges per frame", 64'(rise_cnt), 64'd64);
        ef = exp_frame(wr, p, r, d);
        if (wr) begin
            eoe = '1;
            chk(rec_o == ef, "R4 write frame bits", rec_o, ef);
        end else begin
            eoe = {46'h3FFF_FFFF_FFFF, 18'h0};
            chk(rec_o[63:18] == ef[63:18], "R3 read header bits",
                64'(rec_o[63:18]), 64'(ef[63:18]));
            bus_read(8'h24, v);
            chk(v == d, "R5 read data captured", 64'(v), 64'(d));
        end
        chk(rec_oe == eoe, wr ? "R4 oe pattern" : "R5 oe pattern", rec_oe, eoe);
        chk(!mdc && !mdio_oe, "R8 idle pins", {62'h0, mdc, mdio_oe}, 64'h0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        bit ok;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1 reset state
        bus_read(8'h20, v); chk(v == 0, "R1 cmd reset", 64'(v), 0);
        bus_read(8'h24, v); chk(v == 0, "R1 rdata reset", 64'(v), 0);
        bus_read(8'h28, v); chk(v == 0, "R1 wdata reset", 64'(v), 0);
        chk(!mdc && !mdio_oe, "R1 pins reset", {62'h0, mdc, mdio_oe}, 0);

        // R2 register map
        bus_write(8'h28, 16'hA5C3);
        bus_read(8'h28, v); chk(v == 16'hA5C3, "R2 wdata readback", 64'(v), 64'hA5C3);
        bus_write(8'h24, 16'h1234);
        bus_read(8'h24, v); chk(v == 0, "R2 rdata read-only", 64'(v), 0);
        bus_write(8'h30, 16'hFFFF);
        bus_read(8'h30, v); chk(v == 0, "R2 unused offset", 64'(v), 0);
        rise_cnt = 0;
        bus_write(8'h20, 16'hFFFF);
        bus_read(8'h20, v); chk(v == 16'h5F1F, "R2 cmd field mask", 64'(v), 64'h5F1F);
        wait_free(ok);
        chk(rec_o == exp_frame(1, 5'h1F, 5'h1F, 16'hA5C3), "R2 all-ones cmd frame",
            rec_o, exp_frame(1, 5'h1F, 5'h1F, 16'hA5C3));

        // R8 MDC timing (measured during the frame above)
        chk(period == DIV * 5.0, "R8 MDC period", 64'(int'(period)), 64'(DIV * 5));
        chk(hi_time == DIV * 2.5, "R8 MDC high time", 64'(int'(hi_time * 10)),
            64'(DIV * 25));

        // directed corners
        txn(1'b0, 5'h00, 5'h00, 16'h0000, 1'b0);
        txn(1'b0, 5'h01, 5'h01, 16'h0004, 1'b0);
        txn(1'b1, 5'h00, 5'h00, 16'h0000, 1'b0);
        txn(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 1'b0);
        // R9 both request bits
        txn(1'b1, 5'h03, 5'h04, 16'h3100, 1'b1);

        // R7 command during busy
        rise_cnt = 0;
        bus_write(8'h28, 16'h01E1);
        bus_write(8'h20, {1'b0, 1'b1, 1'b0, 5'h02, 3'b000, 5'h04});
        repeat (20) @(posedge clk);
        bus_write(8'h20, {1'b0, 1'b0, 1'b1, 5'h11, 3'b000, 5'h09});
        bus_read(8'h20, v);
        chk(v == {1'b0, 1'b1, 1'b0, 5'h02, 3'b000, 5'h04}, "R7 busy cmd ignored",
            64'(v), 64'({1'b0, 1'b1, 1'b0, 5'h02, 3'b000, 5'h04}));
        wait_free(ok);
        repeat (10 * DIV) @(posedge clk);
        chk(rise_cnt == 64, "R7 no extra frame", 64'(rise_cnt), 64'd64);
        chk(rec_o == exp_frame(1, 5'h02, 5'h04, 16'h01E1), "R7 frame unchanged",
            rec_o, exp_frame(1, 5'h02, 5'h04, 16'h01E1));

        // constrained random
        for (int k = 0; k < 24; k++) begin
            txn(1'($urandom_range(0, 1)), 5'($urandom), 5'($urandom),
                16'($urandom), 1'b0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule